// File: doc/BRIEF.md
# Peripheral Clock Gating Mask Unit

This unit holds one clock mask register for each of four clock domains: the CPU domain, a high-speed system bus domain, and two peripheral bus domains (PA and PB). It turns those masks into a registered clock enable for each attached module. Here a clock is modelled as an enable signal and is not a real gating cell. Each attached module may draw on any set of the four domains. Module `m` is controlled by bit `m` of the mask of each domain it uses. The module runs only while every one of those bits is 1.

A simple single-cycle register port reaches both the unit's own mask registers and the attached modules' registers. Address bits [7:4] select the target and bits [3:0] select a register inside it. Target 0 is this unit, and target `m+1` is module `m`. Modules take `we_i`, the low address bits and `wdata_i` straight from the shared port, and they are selected by `mod_sel_o`. The unit refuses any access to a module whose enable is low. The unit itself is clocked from PA mask bit `SELF_BIT`, and its bus bridge is clocked from high-speed bus mask bit `BRIDGE_BIT`. Clearing either bit locks the unit out of its own registers until the next reset.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset all four mask registers read 0xFFFFFFFF and every bit of `mod_en_o` is 1.
- R2: A write to unit register `d` stores `wdata_i` in the mask of domain `d`. The domains are 0 = CPU, 1 = high-speed bus, 2 = PA and 3 = PB. A read of that register returns the stored value in the same cycle as the request, with `err_o` low.
- R3: `mod_en_o` is registered. A mask write that commits on clock edge k changes the enable on edge k+1 and not before.
- R4: `mod_en_o[m]` is 1 only when bit `m` is 1 in the mask of every domain that `MOD_DOMS[4m+3:4m]` marks as used. In the default set, module 4 uses the high-speed bus and PA, and module 5 uses the CPU, high-speed bus and PB.
- R5: An access to a module whose enable is 0 raises `err_o`, returns zero read data and leaves `mod_sel_o` all zero.
- R6: An access to an enabled module asserts only the matching bit of `mod_sel_o` and keeps `err_o` low. A read returns that module's `mod_rdata_i` slice, and a write returns zero.
- R7: Writing 1 back to a cleared mask bit restores the module's enable.
- R8: While PA bit `SELF_BIT` (31) or high-speed bus bit `BRIDGE_BIT` (30) is 0, writes to the unit leave all masks unchanged. Reads of the unit return `err_o` high and zero data.
- R9: Reset ends the lockout and sets all masks back to ones.
- R10: Unit register indices 4 to 15 and target numbers above `NUM_MODS` respond with `err_o` high and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Target in [7:4], register in [3:0] |
| wdata_i | input | MASK_W | Write data |
| rdata_o | output | MASK_W | Read data, zero on error |
| err_o | output | 1 | Error response |
| mod_sel_o | output | NUM_MODS | Select for each module, given only while the module is enabled |
| mod_rdata_i | input | NUM_MODS*MASK_W | Read data from the modules, module m at [32m+31:32m] |
| mod_en_o | output | NUM_MODS | Registered clock enable for each module |

## Verification
The hardest state to reach is the lockout. It can only be entered through the same port that it then shuts. Once it is entered, the blocked write is invisible in the mask registers, because they no longer answer reads. The stimulus first clears one module's bit and then trips the lock through either the self bit or the bridge bit. It then writes a restoring value and watches `mod_en_o` stay put. A reset follows each trip and is checked to clear the lock.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int MASK_W  = 32;
  localparam int NUM_DOM = 4;
  localparam int DOM_W   = $clog2(NUM_DOM);

  typedef logic [MASK_W-1:0] mask_t;

  typedef enum logic [DOM_W-1:0] {
    DOM_CPU = 2'd0,
    DOM_HSB = 2'd1,
    DOM_PBA = 2'd2,
    DOM_PBB = 2'd3
  } dom_e;
endpackage

// File: rtl/ckg_mask_regs.sv
module ckg_mask_regs
  import ckg_pkg::*;
#(
  parameter int SELF_BIT   = 31,
  parameter int BRIDGE_BIT = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DOM_W-1:0] wr_dom_i,
  input  mask_t            wr_data_i,
  output mask_t            masks_o [NUM_DOM],
  output logic             locked_o
);
  mask_t masks_q [NUM_DOM];

  // unit loses its own clock or its bridge clock
  assign locked_o = ~masks_q[DOM_PBA][SELF_BIT] | ~masks_q[DOM_HSB][BRIDGE_BIT];

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                           masks_q[d] <= '1;
      else if (wr_en_i && !locked_o && wr_dom_i == DOM_W'(d)) masks_q[d] <= wr_data_i;
    end
    assign masks_o[d] = masks_q[d];

    AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_o |=> $stable(masks_q[d])); // R8
  end
endmodule

// File: rtl/ckg_enable_gen.sv
module ckg_enable_gen
  import ckg_pkg::*;
#(
  parameter int                        NUM_MODS = 6,
  parameter logic [NUM_MODS*NUM_DOM-1:0] MOD_DOMS = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  mask_t               masks_i [NUM_DOM],
  output logic [NUM_MODS-1:0] mod_en_o
);
  logic [NUM_MODS-1:0] en_d;

  always_comb begin
    for (int m = 0; m < NUM_MODS; m++) begin
      en_d[m] = 1'b1;
      for (int d = 0; d < NUM_DOM; d++)
        if (MOD_DOMS[m*NUM_DOM+d] && !masks_i[d][m]) en_d[m] = 1'b0;
    end
  end

  // registered so enables only move on an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mod_en_o <= '1;
    else         mod_en_o <= en_d;
  end

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      if (MOD_DOMS[m*NUM_DOM+d]) begin : g_used
        AST_CLEARED_BIT_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !masks_i[d][m] |=> !mod_en_o[m]); // R4
      end
    end
  end
endmodule

// File: rtl/ckg_access_ctrl.sv
module ckg_access_ctrl
  import ckg_pkg::*;
#(
  parameter int NUM_MODS = 6,
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  mask_t                      masks_i [NUM_DOM],
  input  logic                       locked_i,
  input  logic [NUM_MODS-1:0]        mod_en_i,
  input  logic [NUM_MODS*MASK_W-1:0] mod_rdata_i,
  output mask_t                      rdata_o,
  output logic                       err_o,
  output logic [NUM_MODS-1:0]        mod_sel_o,
  output logic                       mask_wr_en_o,
  output logic [DOM_W-1:0]           mask_wr_dom_o
);
  localparam int TGT_W = ADDR_W - REG_W;

  logic [TGT_W-1:0] tgt;
  logic [REG_W-1:0] reg_idx;
  assign tgt     = addr_i[ADDR_W-1:REG_W];
  assign reg_idx = addr_i[REG_W-1:0];
  assign mask_wr_dom_o = reg_idx[DOM_W-1:0];

  always_comb begin
    rdata_o      = '0;
    err_o        = 1'b0;
    mod_sel_o    = '0;
    mask_wr_en_o = 1'b0;
    if (req_i) begin
      if (tgt == '0) begin
        if (locked_i || reg_idx >= REG_W'(NUM_DOM)) begin
          err_o = 1'b1;
        end else if (we_i) begin
          mask_wr_en_o = 1'b1;
        end else begin
          for (int d = 0; d < NUM_DOM; d++)
            if (reg_idx == REG_W'(d)) rdata_o = masks_i[d];
        end
      end else begin
        err_o = 1'b1;
        for (int m = 0; m < NUM_MODS; m++) begin
          if (tgt == TGT_W'(m + 1) && mod_en_i[m]) begin
            err_o        = 1'b0;
            mod_sel_o[m] = 1'b1;
            if (!we_i) rdata_o = mod_rdata_i[m*MASK_W +: MASK_W];
          end
        end
      end
    end
  end

  AST_NO_SEL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_sel_o & ~mod_en_i) == '0); // R5
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0); // R5
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mod_sel_o)); // R6
  AST_NO_WRITE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |-> !mask_wr_en_o); // R8
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import ckg_pkg::*;
#(
  parameter int NUM_MODS   = 6,
  parameter int ADDR_W     = 8,
  parameter int SELF_BIT   = 31,
  parameter int BRIDGE_BIT = 30,
  // nibble per module: bit0 CPU, bit1 HSB, bit2 PBA, bit3 PBB
  parameter logic [NUM_MODS*4-1:0] MOD_DOMS =
    {4'b1011, 4'b0110, 4'b1000, 4'b0100, 4'b0010, 4'b0001}
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  output logic                       err_o,
  output logic [NUM_MODS-1:0]        mod_sel_o,
  input  logic [NUM_MODS*32-1:0]     mod_rdata_i,
  output logic [NUM_MODS-1:0]        mod_en_o
);
  localparam int REG_W = 4;

  mask_t            masks [NUM_DOM];
  logic             locked;
  logic             mask_wr_en;
  logic [DOM_W-1:0] mask_wr_dom;

  ckg_mask_regs #(
    .SELF_BIT  (SELF_BIT),
    .BRIDGE_BIT(BRIDGE_BIT)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (mask_wr_en),
    .wr_dom_i (mask_wr_dom),
    .wr_data_i(wdata_i),
    .masks_o  (masks),
    .locked_o (locked)
  );

  ckg_enable_gen #(
    .NUM_MODS(NUM_MODS),
    .MOD_DOMS(MOD_DOMS)
  ) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .masks_i (masks),
    .mod_en_o(mod_en_o)
  );

  ckg_access_ctrl #(
    .NUM_MODS(NUM_MODS),
    .ADDR_W  (ADDR_W),
    .REG_W   (REG_W)
  ) u_acc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .masks_i      (masks),
    .locked_i     (locked),
    .mod_en_i     (mod_en_o),
    .mod_rdata_i  (mod_rdata_i),
    .rdata_o      (rdata_o),
    .err_o        (err_o),
    .mod_sel_o    (mod_sel_o),
    .mask_wr_en_o (mask_wr_en),
    .mask_wr_dom_o(mask_wr_dom)
  );

  AST_EN_LAGS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !err_o && addr_i[ADDR_W-1:REG_W] == '0) |-> ##1 $stable(mod_en_o)); // R3
endmodule

// File: tb/sim_clk_gate_ctrl.sv
module sim_clk_gate_ctrl;
  localparam int NM = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req = 1'b0, we = 1'b0;
  logic [7:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic           err;
  logic [NM-1:0]  sel, en;
  logic [NM*32-1:0] mrd;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always_comb
    for (int m = 0; m < NM; m++) mrd[m*32 +: 32] = 32'hA0A0_0000 | 32'(m);

  clk_gate_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .mod_sel_o(sel),
    .mod_rdata_i(mrd), .mod_en_o(en)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        err;
    logic [31:0] rdata;
    logic [5:0]  en;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0,         1'b0, 32'hFFFF_FFFF, 6'h3F, 4'd1},  // R1
    '{1'b0, 8'h03, 32'h0,         1'b0, 32'hFFFF_FFFF, 6'h3F, 4'd1},  // R1
    '{1'b1, 8'h01, 32'hFFFF_FFFD, 1'b0, 32'h0,         6'h3D, 4'd4},  // R4
    '{1'b0, 8'h01, 32'h0,         1'b0, 32'hFFFF_FFFD, 6'h3D, 4'd2},  // R2
    '{1'b0, 8'h20, 32'h0,         1'b1, 32'h0,         6'h3D, 4'd5},  // R5
    '{1'b0, 8'h10, 32'h0,         1'b0, 32'hA0A0_0000, 6'h3D, 4'd6},  // R6
    '{1'b1, 8'h02, 32'hFFFF_FFEF, 1'b0, 32'h0,         6'h2D, 4'd4},  // R4 multi-domain
    '{1'b0, 8'h50, 32'h0,         1'b1, 32'h0,         6'h2D, 4'd5},  // R5
    '{1'b1, 8'h01, 32'hFFFF_FFFF, 1'b0, 32'h0,         6'h2F, 4'd7},  // R7
    '{1'b0, 8'h20, 32'h0,         1'b0, 32'hA0A0_0001, 6'h2F, 4'd7},  // R7
    '{1'b1, 8'h02, 32'hFFFF_FFFF, 1'b0, 32'h0,         6'h3F, 4'd7},  // R7
    '{1'b0, 8'h60, 32'h0,         1'b0, 32'hA0A0_0005, 6'h3F, 4'd6},  // R6
    '{1'b0, 8'h04, 32'h0,         1'b1, 32'h0,         6'h3F, 4'd10}, // R10
    '{1'b0, 8'h70, 32'h0,         1'b1, 32'h0,         6'h3F, 4'd10}, // R10
    '{1'b1, 8'h00, 32'hFFFF_FFDF, 1'b0, 32'h0,         6'h1F, 4'd4},  // R4
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 1'b0, 32'h0,         6'h3F, 4'd7},  // R7
    '{1'b1, 8'h30, 32'h1234_5678, 1'b0, 32'h0,         6'h3F, 4'd6}   // R6
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    req = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    #1;
    chk(en == 6'h3F, "R1", 32'(en), 32'h3F);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].we, VECS[i].addr, VECS[i].wdata);
      chk(err == VECS[i].err, $sformatf("R%0d err v%0d", VECS[i].rq, i), 32'(err), 32'(VECS[i].err));
      chk(rdata == VECS[i].rdata, $sformatf("R%0d rdata v%0d", VECS[i].rq, i), rdata, VECS[i].rdata);
      idle(1);
      chk(en == VECS[i].en, $sformatf("R%0d en v%0d", VECS[i].rq, i), 32'(en), 32'(VECS[i].en));
    end

    // R3: enable one edge after the mask commits
    drive(1'b1, 8'h03, 32'hFFFF_FFF7);
    @(negedge clk);
    req = 1'b0;
    #1;
    chk(en == 6'h3F, "R3 early", 32'(en), 32'h3F);
    @(negedge clk);
    #1;
    chk(en == 6'h37, "R3 late", 32'(en), 32'h37);

    // R5 and R6: select lines
    drive(1'b0, 8'h40, 32'h0);
    chk(sel == 6'h00 && err, "R5 sel", 32'(sel), 32'h0);
    drive(1'b0, 8'h10, 32'h0);
    chk(sel == 6'h01 && !err, "R6 sel", 32'(sel), 32'h1);

    // R8: self-bit lockout
    drive(1'b1, 8'h02, 32'h7FFF_FFFF);
    drive(1'b0, 8'h02, 32'h0);
    chk(err && rdata == 32'h0, "R8 read locked", rdata, 32'h0);
    drive(1'b1, 8'h03, 32'hFFFF_FFFF);
    idle(2);
    chk(en == 6'h37, "R8 write ignored", 32'(en), 32'h37);
    drive(1'b0, 8'h10, 32'h0);
    chk(!err && rdata == 32'hA0A0_0000, "R8 modules live", rdata, 32'hA0A0_0000);

    // R9: reset clears lock
    do_reset();
    chk(en == 6'h3F, "R9 en", 32'(en), 32'h3F);
    drive(1'b0, 8'h03, 32'h0);
    chk(!err && rdata == 32'hFFFF_FFFF, "R9 mask", rdata, 32'hFFFF_FFFF);

    // R8: bridge-bit lockout
    drive(1'b1, 8'h01, 32'hBFFF_FFFF);
    drive(1'b1, 8'h03, 32'hFFFF_FFF7);
    idle(2);
    chk(en == 6'h3F, "R8 bridge write ignored", 32'(en), 32'h3F);
    drive(1'b0, 8'h01, 32'h0);
    chk(err && rdata == 32'h0, "R8 bridge read", rdata, 32'h0);

    do_reset();
    drive(1'b0, 8'h01, 32'h0);
    chk(!err && rdata == 32'hFFFF_FFFF, "R9 bridge", rdata, 32'hFFFF_FFFF);
    idle(1);
    finish_run();
  end
endmodule